// File: doc/BRIEF.md
# Decoded Memory Bus Target

This block is the memory side of a shared processor bus. It watches a 20-bit address bus. It claims only the 128 KB window whose three highest address bits equal `101`, which is byte addresses 0xA0000 through 0xBFFFF. It answers the memory read and write strobes inside that window and ignores every I/O strobe.

An address comparator looks at the address only while the active-low address-valid strobe is low. On a match it pulls an active-low chip select. Behind the comparator sits a byte-wide store:

- **Reads** are combinational. While the chip is selected and the memory-read strobe is low, the store drives the addressed byte on the outgoing data lines and raises an output enable.
- **Writes** commit on the clock edge that first sees the memory-write strobe high again after it was low, provided the chip is selected at that edge.

The store depth is a parameter and may be smaller than the window. In that case, the window address bits above the store's own index are ignored, and locations repeat through the window.

Top module: `memtgt_top`

## Requirements
- R1: `sel_n_o` is low exactly when `addr_vld_n_i` is low and `addr_i[19:17]` equals binary `101`. The window 0xA0000 to 0xBFFFF is selected, and 0x9FFFF and 0xC0000 are not.
- R2: While `addr_vld_n_i` is high, `sel_n_o` stays high whatever the address. A write strobe released in that state stores nothing.
- R3: `rdata_oe_o` is high and `rdata_o` equals the stored byte for the current address when all of the following hold: `sel_n_o` is low, `mem_rd_n_i` is low, and both I/O strobes are high.
- R4: A write commits `wdata_i` at the address on `addr_i` on the first rising clock edge at which `mem_wr_n_i` is sampled high after being sampled low, provided `sel_n_o` is low at that edge.
- R5: A memory-write strobe released while the address is outside the window leaves the store unchanged.
- R6: Either I/O strobe low forces `rdata_oe_o` low. An I/O write pulse never changes the store.
- R7: Whenever `rdata_oe_o` is low, `rdata_o` is zero. After reset with idle strobes, `rdata_oe_o` is low and `sel_n_o` is high.
- R8: The store is indexed by `addr_i[STORE_AW-1:0]` (default 10 bits). Window bits 16 down to STORE_AW do not take part, so 0xA0400 and 0xB0000 reach the same byte as 0xA0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 20 | Bus address |
| wdata_i | input | 8 | Data bus, toward the target |
| rdata_o | output | 8 | Data bus, from the target |
| rdata_oe_o | output | 1 | High while the target drives the data bus |
| addr_vld_n_i | input | 1 | Address valid, active low |
| mem_rd_n_i | input | 1 | Memory read strobe, active low |
| mem_wr_n_i | input | 1 | Memory write strobe, active low |
| io_rd_n_i | input | 1 | I/O read strobe, active low |
| io_wr_n_i | input | 1 | I/O write strobe, active low |
| sel_n_o | output | 1 | Chip select, active low |

## Verification
The bench probes the exact window edges 0x9FFFF, 0xA0000, 0xBFFFF and 0xC0000. A comparator that is off by one bit, or that uses the wrong pattern, would claim a neighbouring region or lose one end of its own.

It releases write strobes with the address invalid, outside the window, and on the I/O write line, then reads the location back. A decoder not gated by the valid strobe, or a store that listened to I/O strobes, would overwrite the byte.

It also reads with an I/O strobe active, which catches a target that fights an I/O device for the data bus. Aliased addresses are read back to confirm that the store index comes only from the low bits.

// File: rtl/memtgt_pkg.sv
package memtgt_pkg;

    localparam int BUS_AW    = 20;
    localparam int DATA_W    = 8;
    localparam int WIN_AW    = 17;
    localparam int SEL_W     = BUS_AW - WIN_AW;
    localparam logic [SEL_W-1:0] WIN_TAG = 3'b101;

    typedef struct packed {
        logic              mrd_n;
        logic              mwr_n;
        logic              iord_n;
        logic              iowr_n;
    } strobes_t;

    typedef struct packed {
        logic [WIN_AW-1:0] offs;
        logic              hit;
    } decode_t;

    function automatic logic may_drive(input logic sel_n, input strobes_t s);
        return !sel_n && !s.mrd_n && s.iord_n && s.iowr_n;
    endfunction

endpackage

// File: rtl/memtgt_decoder.sv
module memtgt_decoder
    import memtgt_pkg::*;
#(
    parameter logic [SEL_W-1:0] TAG = WIN_TAG
) (
    input  logic [BUS_AW-1:0] addr,
    input  logic              vld_n,
    output decode_t           dec,
    output logic              sel_n
);
    logic [SEL_W-1:0] tag_bits;

    assign tag_bits = addr[BUS_AW-1:WIN_AW];
    assign dec.hit  = !vld_n && (tag_bits == TAG);
    assign dec.offs = addr[WIN_AW-1:0];
    assign sel_n    = !dec.hit;
endmodule

// File: rtl/memtgt_wstrobe.sv
module memtgt_wstrobe (
    input  logic clk,
    input  logic rst,
    input  logic mwr_n,
    input  logic sel_n,
    output logic commit
);
    logic mwr_n_q;

    always_ff @(posedge clk) begin
        if (rst) mwr_n_q <= 1'b1;
        else     mwr_n_q <= mwr_n;
    end

    assign commit = !mwr_n_q && mwr_n && !sel_n;
endmodule

// File: rtl/memtgt_ram.sv
module memtgt_ram #(
    parameter int AW = 10,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/memtgt_top.sv
module memtgt_top
    import memtgt_pkg::*;
#(
    parameter int STORE_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_oe_o,
    input  logic              addr_vld_n_i,
    input  logic              mem_rd_n_i,
    input  logic              mem_wr_n_i,
    input  logic              io_rd_n_i,
    input  logic              io_wr_n_i,
    output logic              sel_n_o
);
    decode_t           dec;
    strobes_t          stb;
    logic              sel_n;
    logic              commit;
    logic [STORE_AW-1:0] idx;
    logic [DATA_W-1:0] cell_q;

    assign stb = '{mrd_n: mem_rd_n_i, mwr_n: mem_wr_n_i,
                   iord_n: io_rd_n_i, iowr_n: io_wr_n_i};

    memtgt_decoder u_dec (
        .addr  (addr_i),
        .vld_n (addr_vld_n_i),
        .dec   (dec),
        .sel_n (sel_n)
    );

    memtgt_wstrobe u_wstb (
        .clk    (clk),
        .rst    (rst),
        .mwr_n  (stb.mwr_n),
        .sel_n  (sel_n),
        .commit (commit)
    );

    assign idx = dec.offs[STORE_AW-1:0];

    generate
        if (STORE_AW < WIN_AW) begin : g_alias
            logic unused_alias_bits;
            assign unused_alias_bits = ^{dec.offs[WIN_AW-1:STORE_AW], dec.hit};
        end else begin : g_full
            logic unused_hit_bit;
            assign unused_hit_bit = dec.hit;
        end
    endgenerate

    memtgt_ram #(.AW(STORE_AW), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .we    (commit),
        .waddr (idx),
        .wdata (wdata_i),
        .raddr (idx),
        .rdata (cell_q)
    );

    assign rdata_oe_o = may_drive(sel_n, stb);
    assign rdata_o    = rdata_oe_o ? cell_q : '0;
    assign sel_n_o    = sel_n;
endmodule

// File: rtl/memtgt_checker.sv
module memtgt_checker (
    input logic        clk,
    input logic        rst,
    input logic [19:0] addr_i,
    input logic [7:0]  wdata_i,
    input logic [7:0]  rdata_o,
    input logic        rdata_oe_o,
    input logic        addr_vld_n_i,
    input logic        mem_rd_n_i,
    input logic        mem_wr_n_i,
    input logic        io_rd_n_i,
    input logic        io_wr_n_i,
    input logic        sel_n_o
);
    assert_window_select_R1: assert property (@(posedge clk) disable iff (rst)
        (!addr_vld_n_i && addr_i[19:17] == 3'b101) |-> !sel_n_o);

    assert_invalid_deselect_R2: assert property (@(posedge clk) disable iff (rst)
        addr_vld_n_i |-> sel_n_o);

    assert_drive_needs_read_R3: assert property (@(posedge clk) disable iff (rst)
        rdata_oe_o |-> (!sel_n_o && !mem_rd_n_i));

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_wr_n_i) && !sel_n_o) |=>
        (!(rdata_oe_o && $stable(addr_i)) || rdata_o == $past(wdata_i)));

    assert_io_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
        (!io_rd_n_i || !io_wr_n_i) |-> !rdata_oe_o);

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !rdata_oe_o |-> rdata_o == 8'h00);
endmodule

bind memtgt_top memtgt_checker u_chk (.*);

// File: tb/memtgt_top_bench.sv
module memtgt_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SAW = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        oe;
    logic        vld_n = 1'b1;
    logic        mrd_n = 1'b1;
    logic        mwr_n = 1'b1;
    logic        iord_n = 1'b1;
    logic        iowr_n = 1'b1;
    logic        sel_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memtgt_top u_memtgt_top (
        .clk(clk), .rst(rst), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .rdata_oe_o(oe), .addr_vld_n_i(vld_n),
        .mem_rd_n_i(mrd_n), .mem_wr_n_i(mwr_n), .io_rd_n_i(iord_n),
        .io_wr_n_i(iowr_n), .sel_n_o(sel_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        vld_n = 1; mrd_n = 1; mwr_n = 1; iord_n = 1; iowr_n = 1;
    endtask

    task automatic mem_write(input logic [19:0] a, input logic [7:0] d, input logic v_n);
        @(negedge clk);
        addr = a; wdata = d; vld_n = v_n; mwr_n = 0;
        @(negedge clk);
        mwr_n = 1;
        @(negedge clk);
        go_idle();
    endtask

    task automatic read_expect(input logic [19:0] a, input bit exp_oe,
                               input logic [7:0] exp_d, input string req);
        @(negedge clk);
        addr = a; vld_n = 0; mrd_n = 0;
        #1;
        check(oe == exp_oe, req, oe, exp_oe);
        check(rdata == (exp_oe ? exp_d : 8'h00), req, rdata, exp_oe ? exp_d : 8'h00);
        go_idle();
    endtask

    task automatic t_reset_state();
        check(oe == 0, "R7", oe, 0);
        check(sel_n == 1, "R7", sel_n, 1);
        check(rdata == 0, "R7", rdata, 0);
    endtask

    task automatic t_basic_rw();
        mem_write(20'hA0005, 8'h5A, 0);
        read_expect(20'hA0005, 1, 8'h5A, "R3 R4");
        mem_write(20'hBFFFF, 8'hC3, 0);
        read_expect(20'hBFFFF, 1, 8'hC3, "R1 R4");
        for (int i = 0; i < 6; i++) begin
            mem_write(20'hA0100 + 20'(i), 8'(8'h10 * i + 3), 0);
        end
        for (int i = 0; i < 6; i++) begin
            read_expect(20'hA0100 + 20'(i), 1, 8'(8'h10 * i + 3), "R3");
        end
    endtask

    task automatic t_window_edges();
        @(negedge clk);
        vld_n = 0;
        addr = 20'h9FFFF; #1; check(sel_n == 1, "R1 below", sel_n, 1);
        addr = 20'hA0000; #1; check(sel_n == 0, "R1 low edge", sel_n, 0);
        addr = 20'hBFFFF; #1; check(sel_n == 0, "R1 high edge", sel_n, 0);
        addr = 20'hC0000; #1; check(sel_n == 1, "R1 above", sel_n, 1);
        addr = 20'hE0000; #1; check(sel_n == 1, "R1 other tag", sel_n, 1);
        go_idle();
        read_expect(20'h9FFFF, 0, 8'h00, "R1 R7");
    endtask

    task automatic t_invalid_addr();
        @(negedge clk);
        addr = 20'hA0005; vld_n = 1; mrd_n = 0;
        #1;
        check(sel_n == 1, "R2", sel_n, 1);
        check(oe == 0, "R2", oe, 0);
        go_idle();
        mem_write(20'hA0005, 8'h11, 1);
        read_expect(20'hA0005, 1, 8'h5A, "R2 no store");
    endtask

    task automatic t_outside_write();
        mem_write(20'h80005, 8'hFF, 0);
        mem_write(20'hC0005, 8'hEE, 0);
        read_expect(20'hA0005, 1, 8'h5A, "R5");
    endtask

    task automatic t_io_strobes();
        @(negedge clk);
        addr = 20'hA0005; vld_n = 0; mrd_n = 0; iord_n = 0;
        #1;
        check(oe == 0, "R6 io read", oe, 0);
        check(rdata == 0, "R7 io read", rdata, 0);
        iord_n = 1; iowr_n = 0;
        #1;
        check(oe == 0, "R6 io write", oe, 0);
        go_idle();
        @(negedge clk);
        addr = 20'hA0005; wdata = 8'h22; vld_n = 0; iowr_n = 0;
        @(negedge clk);
        iowr_n = 1;
        @(negedge clk);
        go_idle();
        read_expect(20'hA0005, 1, 8'h5A, "R6 no store");
    endtask

    task automatic t_alias();
        mem_write(20'hA0400, 8'h77, 0);
        read_expect(20'hA0000, 1, 8'h77, "R8");
        read_expect(20'hB0000, 1, 8'h77, "R8");
        mem_write(20'hA0000 + 20'((1 << SAW) - 1), 8'h3C, 0);
        read_expect(20'hBFFFF, 1, 8'h3C, "R8 top");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        t_reset_state();
        t_basic_rw();
        t_window_edges();
        t_invalid_addr();
        t_outside_write();
        t_io_strobes();
        t_alias();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule